// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

The walker turns a 32-bit I/O virtual address into a physical address. It reads a two-level table from memory. A request names an address space, an address and a direction (read or write). The walker takes that address space's directory base from a small register bank. It fetches one directory entry and then one page-table entry. It returns the physical address, the three access attributes and a fault code. Memory is reached through a read port that has only one read in flight at a time.

A small, fully associative entry cache sits in front of the memory port. Both directory entries and page-table entries are kept in it. The key is the entry's physical word address, so an entry read before is served without a memory read. Software can clear the whole cache at once, or clear only the entries that fall in one 16-byte line.

The controller is a state machine with six states:
- `ST_IDLE`: waits for a request. On `req_valid` it moves to `ST_DIR_LOOK`.
- `ST_DIR_LOOK`: looks up the directory entry in the cache. On a miss it moves to `ST_DIR_WAIT`. On a hit it moves to `ST_PTE_LOOK` if the next-level bit is set, and to `ST_REPORT` if it is clear.
- `ST_DIR_WAIT`: reads the directory entry from memory. On the acknowledge it takes the same branch as a hit.
- `ST_PTE_LOOK`: looks up the page-table entry. A hit goes to `ST_REPORT` and a miss goes to `ST_PTE_WAIT`.
- `ST_PTE_WAIT`: reads the page-table entry from memory. On the acknowledge it goes to `ST_REPORT`.
- `ST_REPORT`: presents the result for one cycle and always returns to `ST_IDLE`.

Top module: `iow_walker_top`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_rd_req` are all 0.
- R2: The directory entry is read at word address {base frame (20 bits), iova[31:22], 2'b00}. The base frame is the value stored for `req_asid` at the moment the request is accepted.
- R3: The page-table entry is read at address {directory entry bits 19..0, iova[21:12], 2'b00}.
- R4: A successful walk returns `rsp_paddr` = {page-table entry bits 19..0, iova[11:0]}, `rsp_attr` = page-table entry bits 31..29 (readable, writable, nonsecure) and `rsp_fault` = 0.
- R5: A directory entry with bit 28 clear ends the walk with `rsp_fault` = 1 (not present), `rsp_paddr` = 0 and `rsp_attr` = 0. No page-table entry is read.
- R6: A read request needs page-table entry bit 31. A write request (`req_write`=1) needs bit 30. If the needed bit is clear, the walk returns `rsp_fault` = 2 (permission), `rsp_paddr` = 0, and `rsp_attr` still carries entry bits 31..29. The fault code 3 is never produced.
- R7: There is at most one memory read at a time. `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack`. `busy` is high from the cycle after acceptance through the result cycle. Requests that arrive while `busy` is high are ignored.
- R8: Each accepted request gives exactly one `rsp_valid` pulse, one cycle long.
- R9: An entry already held in the cache is used without a memory read.
- R10: A flush with `flush_type` = 0 invalidates every cached entry.
- R11: A flush with `flush_type` = 1 invalidates only the cached entries whose address bits 31..4 equal `flush_line`. All other entries stay cached.
- R12: `base_we` stores `base_frame` for `base_asid`. Each address space walks from its own base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write enable for the directory base bank |
| base_asid | input | ASID_W | Address space to write |
| base_frame | input | 20 | Directory base frame number |
| req_valid | input | 1 | Translation request |
| req_asid | input | ASID_W | Address space of the request |
| req_iova | input | 32 | I/O virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Entry address being read |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry word returned |
| flush_valid | input | 1 | Cache flush command |
| flush_type | input | 1 | 0 = everything, 1 = one line |
| flush_line | input | 28 | Entry address bits 31..4 for a line flush |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_attr | output | 3 | Readable, writable, nonsecure |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 permission |

## Verification
Walks run through every path a result can take:
- A cold walk with two memory reads pins down the address arithmetic at both levels.
- A repeat walk with no reads shows that cache hits work.
- A walk that hits the directory entry but misses the page-table entry separates the two lookups.
- A directory entry without the next-level bit, and entries that lack the read or the write permission, tell the three fault codes apart.
- A second address space with its own base shows that the bank is selected per request.
- A line flush followed by two walks shows that only the matching line is dropped. A full flush forces both reads again.
- A request poked in while the walker is busy checks that it is ignored.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int ADDR_W     = 32;
    localparam int FRAME_W    = 20;
    localparam int IDX_W      = 10;
    localparam int OFFS_W     = 12;
    localparam int NEXT_BIT   = 28;
    localparam int RD_BIT     = 31;
    localparam int WR_BIT     = 30;
    localparam int NS_BIT     = 29;
    localparam int WORD_LSB   = 2;
    localparam int LINE_LSB   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_LOOK,
        ST_DIR_WAIT,
        ST_PTE_LOOK,
        ST_PTE_WAIT,
        ST_REPORT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;

    // Build a table entry word address from a frame and a 10-bit index.
    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [FRAME_W-1:0] frame,
        input logic [IDX_W-1:0]   idx
    );
        return {frame, idx, 2'b00};
    endfunction

endpackage

// File: rtl/iow_base_bank.sv
module iow_base_bank #(
    parameter int ASID_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic [iow_pkg::FRAME_W-1:0] wr_frame,
    input  logic [ASID_W-1:0]          rd_asid,
    output logic [iow_pkg::FRAME_W-1:0] rd_frame
);
    import iow_pkg::*;

    localparam int NUM_AS = 1 << ASID_W;

    logic [FRAME_W-1:0] base_r [NUM_AS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AS; i++) begin
                base_r[i] <= '0;
            end
        end else if (wr_en) begin
            base_r[wr_asid] <= wr_frame;
        end
    end

    assign rd_frame = base_r[rd_asid];

endmodule

// File: rtl/iow_entry_cache.sv
module iow_entry_cache #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:2] look_addr,
    output logic        look_hit,
    output logic [31:0] look_data,
    input  logic        fill_en,
    input  logic [31:2] fill_addr,
    input  logic [31:0] fill_data,
    input  logic        flush_en,
    input  logic        flush_all,
    input  logic [31:4] flush_line
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int TAG_W = 30;

    logic [TAG_W-1:0] tag_r   [DEPTH];
    logic [31:0]      data_r  [DEPTH];
    logic [DEPTH-1:0] valid_r;
    logic [PTR_W-1:0] victim_r;

    logic [DEPTH-1:0] slot_hit;
    logic [DEPTH-1:0] slot_fill;
    logic [DEPTH-1:0] slot_drop;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TAG_W-1:0] next_tag;
        assign slot_hit[g]  = valid_r[g] && (tag_r[g] == look_addr);
        assign slot_fill[g] = fill_en && (victim_r == PTR_W'(g));
        assign next_tag     = slot_fill[g] ? fill_addr : tag_r[g];
        // A flush is checked against the tag the slot holds after this
        // cycle, so a matching fill in the same cycle is dropped.
        assign slot_drop[g] = flush_en &&
                              (flush_all || (next_tag[TAG_W-1:2] == flush_line));
    end

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_hit[i]) begin
                look_hit  = 1'b1;
                look_data = look_data | data_r[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r  <= '0;
            victim_r <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_r[i]  <= '0;
                data_r[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_fill[i]) begin
                    tag_r[i]   <= fill_addr;
                    data_r[i]  <= fill_data;
                    valid_r[i] <= 1'b1;
                end
                if (slot_drop[i]) begin
                    valid_r[i] <= 1'b0;
                end
            end
            if (fill_en) begin
                victim_r <= (victim_r == PTR_W'(DEPTH - 1)) ? '0 : victim_r + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iow_walk_fsm.sv
module iow_walk_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_iova,
    input  logic        req_write,
    input  logic [19:0] req_base,
    input  logic        look_hit,
    input  logic [31:0] look_data,
    output logic [31:0] cur_addr,
    output logic        fill_en,
    input  logic        mem_rd_ack,
    input  logic [31:0] mem_rd_data,
    output logic        busy,
    output logic        mem_rd_req,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_attr,
    output logic [1:0]  rsp_fault
);
    import iow_pkg::*;

    walk_state_e state_q;
    walk_state_e state_d;

    logic [31:0]        iova_q;
    logic               write_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] pde_frame_q;
    logic [31:0]        paddr_q;
    logic [2:0]         attr_q;
    fault_e             fault_q;

    logic [31:0] dir_addr;
    logic [31:0] pte_addr;
    logic [31:0] entry_word;
    logic        in_look;
    logic        dir_ready;
    logic        pte_ready;
    logic        perm_ok;

    assign dir_addr = entry_addr(base_q, iova_q[31:22]);
    assign pte_addr = entry_addr(pde_frame_q, iova_q[21:12]);

    assign in_look    = (state_q == ST_DIR_LOOK) || (state_q == ST_PTE_LOOK);
    assign entry_word = in_look ? look_data : mem_rd_data;
    assign dir_ready  = ((state_q == ST_DIR_LOOK) && look_hit) ||
                        ((state_q == ST_DIR_WAIT) && mem_rd_ack);
    assign pte_ready  = ((state_q == ST_PTE_LOOK) && look_hit) ||
                        ((state_q == ST_PTE_WAIT) && mem_rd_ack);
    assign perm_ok    = write_q ? entry_word[WR_BIT] : entry_word[RD_BIT];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_DIR_LOOK;
            end
            ST_DIR_LOOK: begin
                if (!look_hit)                 state_d = ST_DIR_WAIT;
                else if (look_data[NEXT_BIT])  state_d = ST_PTE_LOOK;
                else                           state_d = ST_REPORT;
            end
            ST_DIR_WAIT: begin
                if (mem_rd_ack) begin
                    state_d = mem_rd_data[NEXT_BIT] ? ST_PTE_LOOK : ST_REPORT;
                end
            end
            ST_PTE_LOOK: begin
                state_d = look_hit ? ST_REPORT : ST_PTE_WAIT;
            end
            ST_PTE_WAIT: begin
                if (mem_rd_ack) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iova_q      <= '0;
            write_q     <= 1'b0;
            base_q      <= '0;
            pde_frame_q <= '0;
            paddr_q     <= '0;
            attr_q      <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                iova_q  <= req_iova;
                write_q <= req_write;
                base_q  <= req_base;
            end
            if (dir_ready) begin
                pde_frame_q <= entry_word[FRAME_W-1:0];
                if (!entry_word[NEXT_BIT]) begin
                    paddr_q <= '0;
                    attr_q  <= '0;
                    fault_q <= FLT_ABSENT;
                end
            end
            if (pte_ready) begin
                attr_q <= entry_word[RD_BIT:NS_BIT];
                if (perm_ok) begin
                    paddr_q <= {entry_word[FRAME_W-1:0], iova_q[OFFS_W-1:0]};
                    fault_q <= FLT_NONE;
                end else begin
                    paddr_q <= '0;
                    fault_q <= FLT_PERM;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        mem_rd_req = (state_q == ST_DIR_WAIT) || (state_q == ST_PTE_WAIT);
        rsp_valid  = (state_q == ST_REPORT);
        fill_en    = mem_rd_req && mem_rd_ack;
        cur_addr   = ((state_q == ST_DIR_LOOK) || (state_q == ST_DIR_WAIT)) ?
                     dir_addr : pte_addr;
        rsp_paddr  = paddr_q;
        rsp_attr   = attr_q;
        rsp_fault  = fault_q;
    end

endmodule

// File: rtl/iow_walker_top.sv
module iow_walker_top #(
    parameter int ASID_W      = 2,
    parameter int CACHE_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ASID_W-1:0] base_asid,
    input  logic [19:0]       base_frame,
    input  logic              req_valid,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [31:0]       req_iova,
    input  logic              req_write,
    output logic              busy,
    output logic              mem_rd_req,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [31:0]       mem_rd_data,
    input  logic              flush_valid,
    input  logic              flush_type,
    input  logic [27:0]       flush_line,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic [2:0]        rsp_attr,
    output logic [1:0]        rsp_fault
);
    logic [19:0] sel_base;
    logic        look_hit;
    logic [31:0] look_data;
    logic [31:0] cur_addr;
    logic        fill_en;

    iow_base_bank #(.ASID_W(ASID_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_we),
        .wr_asid  (base_asid),
        .wr_frame (base_frame),
        .rd_asid  (req_asid),
        .rd_frame (sel_base)
    );

    iow_entry_cache #(.DEPTH(CACHE_DEPTH)) cache_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_addr  (cur_addr[31:2]),
        .look_hit   (look_hit),
        .look_data  (look_data),
        .fill_en    (fill_en),
        .fill_addr  (cur_addr[31:2]),
        .fill_data  (mem_rd_data),
        .flush_en   (flush_valid),
        .flush_all  (!flush_type),
        .flush_line (flush_line)
    );

    iow_walk_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_iova    (req_iova),
        .req_write   (req_write),
        .req_base    (sel_base),
        .look_hit    (look_hit),
        .look_data   (look_data),
        .cur_addr    (cur_addr),
        .fill_en     (fill_en),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .mem_rd_req  (mem_rd_req),
        .rsp_valid   (rsp_valid),
        .rsp_paddr   (rsp_paddr),
        .rsp_attr    (rsp_attr),
        .rsp_fault   (rsp_fault)
    );

    assign mem_rd_addr = cur_addr;

endmodule

// File: rtl/iow_checker.sv
module iow_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_iova,
    input logic        req_write,
    input logic        busy,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ack,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_attr,
    input logic [1:0]  rsp_fault
);
    logic [11:0] offs_q;
    logic        dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offs_q <= '0;
            dir_q  <= 1'b0;
        end else if (req_valid && !busy) begin
            offs_q <= req_iova[11:0];
            dir_q  <= req_write;
        end
    end

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R7
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    absent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |-> (rsp_paddr == 32'd0 && rsp_attr == 3'd0));

    // R6
    perm_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (dir_q ? rsp_attr[1] : rsp_attr[2]));

    // R6
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

    // R4
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[11:0] == offs_q));

endmodule

bind iow_walker_top iow_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_iova    (req_iova),
    .req_write   (req_write),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_attr    (rsp_attr),
    .rsp_fault   (rsp_fault)
);

// File: tb/iow_walker_top_tb_top.sv
`timescale 1ns/1ps
module iow_walker_top_tb_top;

    localparam int ASID_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_we = 1'b0;
    logic [ASID_W-1:0] base_asid = '0;
    logic [19:0]       base_frame = '0;
    logic              req_valid = 1'b0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [31:0]       req_iova = '0;
    logic              req_write = 1'b0;
    logic              busy;
    logic              mem_rd_req;
    logic [31:0]       mem_rd_addr;
    logic              mem_rd_ack = 1'b0;
    logic [31:0]       mem_rd_data = '0;
    logic              flush_valid = 1'b0;
    logic              flush_type = 1'b0;
    logic [27:0]       flush_line = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_paddr;
    logic [2:0]        rsp_attr;
    logic [1:0]        rsp_fault;

    always #2.5 clk = ~clk;

    iow_walker_top #(.ASID_W(ASID_W), .CACHE_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_asid(base_asid), .base_frame(base_frame),
        .req_valid(req_valid), .req_asid(req_asid), .req_iova(req_iova),
        .req_write(req_write), .busy(busy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .flush_valid(flush_valid), .flush_type(flush_type), .flush_line(flush_line),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_attr(rsp_attr), .rsp_fault(rsp_fault)
    );

    int n_checks = 0;
    int n_bad    = 0;
    int n_rsp    = 0;
    int n_sent   = 0;

    logic [31:0] mem_model [bit [31:0]];
    logic [19:0] base_model [4];
    logic [31:0] rd_log [$];

    logic [31:0] exp_paddr_q [$];
    logic [2:0]  exp_attr_q  [$];
    logic [1:0]  exp_fault_q [$];
    string       exp_tag_q   [$];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory responder: one cycle of latency, logs every read address
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                rd_log.push_back(mem_rd_addr);
                @(negedge clk);
                mem_rd_ack  = 1'b1;
                mem_rd_data = mem_rd(mem_rd_addr);
                @(negedge clk);
                mem_rd_ack  = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                n_rsp++;
                if (exp_tag_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected response", rsp_paddr, 32'd0);
                end else begin
                    automatic logic [31:0] ep = exp_paddr_q.pop_front();
                    automatic logic [2:0]  ea = exp_attr_q.pop_front();
                    automatic logic [1:0]  ef = exp_fault_q.pop_front();
                    automatic string       et = exp_tag_q.pop_front();
                    chk(rsp_fault == ef, et, "fault", 32'(rsp_fault), 32'(ef));
                    chk(rsp_paddr == ep, et, "paddr", rsp_paddr, ep);
                    chk(rsp_attr == ea, et, "attr", 32'(rsp_attr), 32'(ea));
                end
            end
        end
    end

    task automatic set_base(input int asid, input logic [19:0] frame);
        @(negedge clk);
        base_we = 1'b1; base_asid = ASID_W'(asid); base_frame = frame;
        @(negedge clk);
        base_we = 1'b0;
        base_model[asid] = frame;
    endtask

    task automatic flush(input bit by_line, input logic [31:0] addr);
        @(negedge clk);
        flush_valid = 1'b1; flush_type = by_line; flush_line = addr[31:4];
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    // Driver: reference walk from the requirements, push expectation, drive
    task automatic walk(input int asid, input logic [31:0] iova, input bit wr,
                        input bit exp_dir_rd, input bit exp_pte_rd,
                        input string tag, input bit poke);
        logic [31:0] da, pa, pde, pte;
        logic [31:0] ep;
        logic [2:0]  ea;
        logic [1:0]  ef;
        int          n_exp;
        da  = {base_model[asid], iova[31:22], 2'b00};          // R2
        pde = mem_rd(da);
        pa  = {pde[19:0], iova[21:12], 2'b00};                  // R3
        pte = mem_rd(pa);
        if (!pde[28]) begin
            ep = 32'd0; ea = 3'd0; ef = 2'd1;                    // R5
        end else if (wr ? pte[30] : pte[31]) begin
            ep = {pte[19:0], iova[11:0]}; ea = pte[31:29]; ef = 2'd0;  // R4
        end else begin
            ep = 32'd0; ea = pte[31:29]; ef = 2'd2;              // R6
        end
        exp_paddr_q.push_back(ep);
        exp_attr_q.push_back(ea);
        exp_fault_q.push_back(ef);
        exp_tag_q.push_back(tag);
        rd_log.delete();
        n_sent++;
        @(negedge clk);
        req_valid = 1'b1; req_asid = ASID_W'(asid); req_iova = iova; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            req_valid = 1'b1; req_iova = 32'h00403000; req_write = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        n_exp = int'(exp_dir_rd) + int'(exp_pte_rd);
        chk(rd_log.size() == n_exp, tag, "memory read count",
            32'(rd_log.size()), 32'(n_exp));
        if (rd_log.size() == n_exp) begin
            if (exp_dir_rd) chk(rd_log[0] == da, "R2", "dir address", rd_log[0], da);
            if (exp_pte_rd) chk(rd_log[n_exp-1] == pa, "R3", "pte address",
                                rd_log[n_exp-1], pa);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        chk(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) base_model[i] = '0;
        // Address space 0 tables
        mem_model[32'h0001_0004] = 32'hF000_0030;  // present, table at 0x30000
        mem_model[32'h0003_000C] = 32'hC001_2345;  // R+W
        mem_model[32'h0003_0010] = 32'h8000_0777;  // read only
        mem_model[32'h0001_0FFC] = 32'hE000_0040;  // next-level bit clear
        // Address space 1 tables
        mem_model[32'h0002_0004] = 32'h1000_0050;  // present, table at 0x50000
        mem_model[32'h0005_000C] = 32'h6000_ABCD;  // W+NS, not readable

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", 32'(busy), 32'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_rd_req == 1'b0, "R1", "mem_rd_req", 32'(mem_rd_req), 32'd0);

        set_base(0, 20'h00010);
        set_base(1, 20'h00020);                       // R12

        walk(0, 32'h0040_3ABC, 1'b0, 1, 1, "R4", 0);  // cold walk
        walk(0, 32'h0040_3ABC, 1'b0, 0, 0, "R9", 0);  // both cached
        walk(0, 32'h0040_4010, 1'b1, 0, 1, "R6", 0);  // write to read-only
        walk(0, 32'h0040_4010, 1'b0, 0, 0, "R9", 0);  // read ok, cached
        walk(0, 32'hFFC0_0123, 1'b0, 1, 0, "R5", 0);  // absent
        walk(1, 32'h0040_3ABC, 1'b0, 1, 1, "R12", 0); // other base, no read perm
        walk(1, 32'h0040_3ABC, 1'b1, 0, 0, "R12", 0); // write allowed

        flush(1'b1, 32'h0003_0010);                   // R11 drop one line
        walk(0, 32'h0040_4010, 1'b0, 0, 1, "R11", 0);
        walk(0, 32'h0040_3ABC, 1'b0, 0, 0, "R11", 0);

        flush(1'b0, 32'h0);                           // R10 drop everything
        walk(0, 32'h0040_3ABC, 1'b0, 1, 1, "R10", 1); // with an ignored poke

        repeat (4) @(negedge clk);
        // R8 one response per accepted request; R7 poke ignored
        chk(n_rsp == n_sent, "R8", "response count", 32'(n_rsp), 32'(n_sent));
        chk(exp_tag_q.size() == 0, "R7", "pending expectations",
            32'(exp_tag_q.size()), 32'd0);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule